// File: doc/BRIEF.md
# Keyed-Lock NOR Flash Program/Erase Controller

This block sits between a simple 32-bit register bus and an embedded NOR flash array. Software unlocks the control registers with a key and enables writing. It then loads a target address into an address buffer and latches it with a command. A word is programmed by writing a data register while the data-ready flag is up and then issuing a program command. A page is erased with a single erase command.

Each latched address is checked against the flash size, word alignment and a per-page lock table supplied as an input vector. Accesses to protected or out-of-range locations are reported in the status register and are never started. A busy flag covers each operation for a fixed, parameterised number of cycles. At the end of the operation the block issues a one-cycle strobe to the array. For a program the stored word takes the AND of old and new data. For an erase the whole page becomes all ones.

Top module: `nvm_ctrl`

## Requirements
- R1: After reset, status (offset 0x01C) reads 0x00000008 (only data-ready, bit 3, set), the lock register (0x03C) reads 1, write-control (0x008) reads 0, and any offset not listed in these requirements reads 0. Read data appears on `bus_rdata` one clock after the read request.
- R2: Writing 0x00001B71 to the lock register unlocks the block, and it then reads 0. Writing any other value relocks it, and it then reads 1. While locked, writes to write-control, command (0x00C), address buffer (0x010) and write data (0x018) have no effect.
- R3: Bit 0 of write-control is the write enable. While it is 0, program (command bit 3) and erase (command bit 1) start no operation and no array strobe.
- R4: Command bit 0 copies the address buffer into the internal address. It sets status bit 2 (invalid) when the address is at or above FLASH_BYTES or not a multiple of 4. Otherwise it sets status bit 1 (locked) when bit p of `page_lock` is 0, with p = address / PAGE_BYTES. It also clears status bits 4 and 5. A command write with bit 0 set performs only the latch.
- R5: A write to the data register is taken only while status bit 3 is 1. Taking it clears bit 3, and later writes are ignored until the pending word has been programmed, when bit 3 returns to 1.
- R6: An accepted program keeps status bit 0 (busy) high for exactly PROG_CYCLES cycles. It then pulses `arr_prog` for one cycle with the latched address and pending data, and the internal address advances by 4 with its flags re-evaluated.
- R7: An accepted erase keeps busy high for exactly ERASE_CYCLES cycles. It then pulses `arr_erase` for one cycle with the page base address of the latched address. When both erase and program bits are set, erase wins.
- R8: Program or erase issued while status bit 1 or bit 2 is set starts nothing. A rejected erase sets status bit 5 (erase aborted).
- R9: Program issued while status bit 3 is 1 (no pending data) starts nothing and sets status bit 4 (word timeout).
- R10: Command writes made while busy is high are ignored, including the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_off | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| page_lock | input | NUM_PAGES | Per-page protection, 0 = page protected |
| arr_prog | output | 1 | One-cycle program strobe to the array |
| arr_erase | output | 1 | One-cycle page-erase strobe to the array |
| arr_addr | output | log2(FLASH_BYTES) | Byte address of the word or page base |
| arr_wdata | output | 32 | Word to AND into the array |

## Verification
The assertions assume one bus access per cycle with `bus_off` and `bus_wdata` free of unknowns whenever `bus_sel` is high. They also assume `page_lock` does not change between a latch and the operation that follows, because the protection flags are captured at latch time. The stimulus drives every bus field on the falling edge, holds each request for exactly one cycle and keeps the lock table constant for the whole run. It exercises commands while locked, with write enable clear, during busy, and against protected, misaligned and out-of-range addresses.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  localparam int DW = 32;
  localparam int OW = 8;

  localparam logic [OW-1:0] OFF_WCTL  = 8'h08;
  localparam logic [OW-1:0] OFF_CMD   = 8'h0C;
  localparam logic [OW-1:0] OFF_ADDRB = 8'h10;
  localparam logic [OW-1:0] OFF_WDATA = 8'h18;
  localparam logic [OW-1:0] OFF_STAT  = 8'h1C;
  localparam logic [OW-1:0] OFF_KEY   = 8'h3C;

  localparam logic [DW-1:0] UNLOCK_KEY = 32'h0000_1B71;

  localparam int CMD_LATCH = 0;
  localparam int CMD_ERASE = 1;
  localparam int CMD_PROG  = 3;

  typedef struct packed {
    logic eabort;
    logic wtimeout;
    logic dready;
    logic invalid;
    logic locked;
    logic busy;
  } stat_t;
endpackage

// File: rtl/nvm_key_gate.sv
module nvm_key_gate
  import nvm_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_stb,
  input  logic [OW-1:0] off,
  input  logic [DW-1:0] wdata,
  output logic          unlocked,
  output logic          wren
);
  always_ff @(posedge clk) begin
    if (rst) begin
      unlocked <= 1'b0;
      wren     <= 1'b0;
    end else if (wr_stb) begin
      if (off == OFF_KEY)
        unlocked <= (wdata == UNLOCK_KEY);
      else if (off == OFF_WCTL && unlocked)
        wren <= wdata[0];
    end
  end

  // R2: write enable cannot move while the key is absent
  p_wren_keyed_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(unlocked) |-> $stable(wren));
endmodule

// File: rtl/nvm_page_check.sv
module nvm_page_check #(
  parameter int FLASH_BYTES = 65536,
  parameter int PAGE_BYTES  = 2048,
  parameter int NUM_PAGES   = FLASH_BYTES / PAGE_BYTES
) (
  input  logic [31:0]          addr,
  input  logic [NUM_PAGES-1:0] page_lock,
  output logic                 locked,
  output logic                 invalid
);
  localparam int PG_SHIFT = $clog2(PAGE_BYTES);
  localparam int PGW      = $clog2(NUM_PAGES);

  logic [PGW-1:0] page_idx;

  always_comb begin
    page_idx = addr[PG_SHIFT +: PGW];
    invalid  = (addr >= 32'(FLASH_BYTES)) || (addr[1:0] != 2'b00);
    locked   = !invalid && !page_lock[page_idx];
  end
endmodule

// File: rtl/nvm_op_timer.sv
module nvm_op_timer #(
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic start_erase,
  output logic busy,
  output logic done,
  output logic op_erase
);
  localparam int MAXC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      cnt      <= '0;
      op_erase <= 1'b0;
    end else if (start && !busy) begin
      busy     <= 1'b1;
      op_erase <= start_erase;
      cnt      <= start_erase ? CW'(ERASE_CYCLES - 1) : CW'(PROG_CYCLES - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  // checker: independent count of cycles spent busy
  logic [CW:0] chk_len;
  always_ff @(posedge clk) begin
    if (rst)                chk_len <= '0;
    else if (start && !busy) chk_len <= (CW+1)'(1);
    else if (busy && !done)  chk_len <= chk_len + 1'b1;
  end

  // R6 / R7: busy window length matches the operation type
  p_busy_len_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> chk_len == (op_erase ? (CW+1)'(ERASE_CYCLES) : (CW+1)'(PROG_CYCLES)));

  // R10: the controller never requests a start while an operation runs
  p_no_restart_r10: assert property (@(posedge clk) disable iff (rst)
    busy |-> !start);
endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
  import nvm_pkg::*;
#(
  parameter int FLASH_BYTES  = 65536,
  parameter int PAGE_BYTES   = 2048,
  parameter int NUM_PAGES    = FLASH_BYTES / PAGE_BYTES,
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 64
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           bus_sel,
  input  logic                           bus_wr,
  input  logic [7:0]                     bus_off,
  input  logic [31:0]                    bus_wdata,
  output logic [31:0]                    bus_rdata,
  input  logic [NUM_PAGES-1:0]           page_lock,
  output logic                           arr_prog,
  output logic                           arr_erase,
  output logic [$clog2(FLASH_BYTES)-1:0] arr_addr,
  output logic [31:0]                    arr_wdata
);
  localparam int AW       = $clog2(FLASH_BYTES);
  localparam int PG_SHIFT = $clog2(PAGE_BYTES);

  logic wr_stb, rd_stb;
  logic unlocked, wren;
  logic busy, done, op_erase;
  logic cmd_wr, do_latch, req_erase, req_prog, blocked, go_erase, go_prog;
  logic prog_done, erase_done, addr_load;
  logic [31:0] addrb, cur_addr, addr_nxt, data_r;
  logic nxt_lock, nxt_inv;
  stat_t st;
  logic [31:0] rd_mux;

  assign wr_stb = bus_sel && bus_wr;
  assign rd_stb = bus_sel && !bus_wr;

  nvm_key_gate u_key (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .off(bus_off),
    .wdata(bus_wdata), .unlocked(unlocked), .wren(wren)
  );

  // command decode: latch wins over everything, erase over program
  always_comb begin
    cmd_wr    = wr_stb && (bus_off == OFF_CMD) && unlocked && !busy;
    do_latch  = cmd_wr && bus_wdata[CMD_LATCH];
    req_erase = cmd_wr && !bus_wdata[CMD_LATCH] && bus_wdata[CMD_ERASE] && wren;
    req_prog  = cmd_wr && !bus_wdata[CMD_LATCH] && !bus_wdata[CMD_ERASE]
                && bus_wdata[CMD_PROG] && wren;
    blocked   = st.locked || st.invalid;
    go_erase  = req_erase && !blocked;
    go_prog   = req_prog && !blocked && !st.dready;
  end

  nvm_op_timer #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_tmr (
    .clk(clk), .rst(rst), .start(go_erase || go_prog), .start_erase(go_erase),
    .busy(busy), .done(done), .op_erase(op_erase)
  );

  assign prog_done  = done && !op_erase;
  assign erase_done = done && op_erase;
  assign addr_load  = do_latch || prog_done;
  assign addr_nxt   = do_latch ? addrb : cur_addr + 32'd4;

  nvm_page_check #(.FLASH_BYTES(FLASH_BYTES), .PAGE_BYTES(PAGE_BYTES),
                   .NUM_PAGES(NUM_PAGES)) u_chk (
    .addr(addr_nxt), .page_lock(page_lock), .locked(nxt_lock), .invalid(nxt_inv)
  );

  always_comb begin
    st.busy = busy;
    unique case (bus_off)
      OFF_KEY:   rd_mux = {31'd0, !unlocked};
      OFF_WCTL:  rd_mux = {31'd0, wren};
      OFF_ADDRB: rd_mux = addrb;
      OFF_STAT:  rd_mux = {26'd0, st};
      default:   rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addrb       <= '0;
      cur_addr    <= '0;
      data_r      <= '0;
      st.locked   <= 1'b0;
      st.invalid  <= 1'b0;
      st.dready   <= 1'b1;
      st.wtimeout <= 1'b0;
      st.eabort   <= 1'b0;
      arr_prog    <= 1'b0;
      arr_erase   <= 1'b0;
      arr_addr    <= '0;
      arr_wdata   <= '0;
      bus_rdata   <= '0;
    end else begin
      arr_prog  <= 1'b0;
      arr_erase <= 1'b0;
      if (rd_stb) bus_rdata <= rd_mux;
      if (wr_stb && unlocked && bus_off == OFF_ADDRB) addrb <= bus_wdata;
      if (wr_stb && unlocked && bus_off == OFF_WDATA && st.dready) begin
        data_r    <= bus_wdata;
        st.dready <= 1'b0;
      end
      if (addr_load) begin
        cur_addr   <= addr_nxt;
        st.locked  <= nxt_lock;
        st.invalid <= nxt_inv;
      end
      if (do_latch) begin
        st.wtimeout <= 1'b0;
        st.eabort   <= 1'b0;
      end
      if (req_erase && blocked)                 st.eabort   <= 1'b1;
      if (req_prog && !blocked && st.dready)    st.wtimeout <= 1'b1;
      if (prog_done) begin
        arr_prog  <= 1'b1;
        arr_addr  <= cur_addr[AW-1:0];
        arr_wdata <= data_r;
        st.dready <= 1'b1;
      end
      if (erase_done) begin
        arr_erase <= 1'b1;
        arr_addr  <= {cur_addr[AW-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
      end
    end
  end

  // R3: an operation only begins with the key in place and writing enabled
  p_start_keyed_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(unlocked && wren));

  // R8: an operation never begins on a protected or invalid address
  p_start_clean_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(!st.locked && !st.invalid));

  // R6 / R7: array strobes follow the end of the busy window
  p_strobe_after_busy_r6: assert property (@(posedge clk) disable iff (rst)
    (arr_prog || arr_erase) |-> $fell(busy));

  // R7: never both strobes at once
  p_one_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    !(arr_prog && arr_erase));

  // R4: programmed words are always aligned
  p_prog_aligned_r4: assert property (@(posedge clk) disable iff (rst)
    arr_prog |-> arr_addr[1:0] == 2'b00);

  // R5: a program consumes pending data and raises data-ready when done
  p_prog_needs_data_r5: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy) && !op_erase) |-> !st.dready);
  p_ready_back_r5: assert property (@(posedge clk) disable iff (rst)
    arr_prog |-> st.dready);
endmodule

// File: tb/sim_nvm_ctrl.sv
module sim_nvm_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int FB    = 4096;
  localparam int PB    = 256;
  localparam int NP    = FB / PB;
  localparam int PC    = 8;
  localparam int EC    = 64;
  localparam int AW    = $clog2(FB);
  localparam int WORDS = FB / 4;
  localparam logic [31:0] INIT_W = 32'h3C3C_C3C3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_off = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] page_lock = 16'hFFF7;   // page 3 protected
  logic arr_prog, arr_erase;
  logic [AW-1:0] arr_addr;
  logic [31:0] arr_wdata;

  int n_checks = 0;
  int n_err = 0;
  int prog_cnt = 0, erase_cnt = 0;
  logic [AW-1:0] last_paddr = '0, last_eaddr = '0;
  logic [31:0] mem [WORDS];

  always #(CLK_PERIOD/2) clk = ~clk;

  nvm_ctrl #(.FLASH_BYTES(FB), .PAGE_BYTES(PB), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_off(bus_off),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .page_lock(page_lock),
    .arr_prog(arr_prog), .arr_erase(arr_erase), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
  );

  // behavioural array model
  initial for (int i = 0; i < WORDS; i++) mem[i] = INIT_W;
  always @(negedge clk) begin
    if (arr_prog) begin
      mem[arr_addr >> 2] = mem[arr_addr >> 2] & arr_wdata;
      prog_cnt++;
      last_paddr = arr_addr;
    end
    if (arr_erase) begin
      for (int i = 0; i < PB / 4; i++) mem[(arr_addr >> 2) + i] = 32'hFFFF_FFFF;
      erase_cnt++;
      last_eaddr = arr_addr;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // tasks start and end on a falling edge
  task automatic bw(input logic [7:0] off, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_off = off; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic br(input logic [7:0] off, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_off = off;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic busy_reads(output int n);
    logic [31:0] s;
    n = 0;
    for (int k = 0; k < 200; k++) begin
      br(8'h1C, s);
      if (!s[0]) break;
      n++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic latch(input logic [31:0] a);
    bw(8'h10, a);
    bw(8'h0C, 32'h1);
  endtask

  task automatic t_reset;
    logic [31:0] r;
    br(8'h1C, r); check("R1 status after reset", r, 32'h08);
    br(8'h3C, r); check("R1 lock reads locked", r, 32'h1);
    br(8'h08, r); check("R1 write-control clear", r, 32'h0);
    br(8'h20, r); check("R1 unlisted offset", r, 32'h0);
  endtask

  task automatic t_key;
    logic [31:0] r;
    bw(8'h08, 32'h1);
    br(8'h08, r); check("R2 wctl ignored while locked", r, 32'h0);
    bw(8'h10, 32'h104);
    br(8'h10, r); check("R2 addr buffer ignored while locked", r, 32'h0);
    bw(8'h3C, 32'h1B71);
    br(8'h3C, r); check("R2 key unlocks", r, 32'h0);
    bw(8'h08, 32'h1);
    br(8'h08, r); check("R2 wctl writable", r, 32'h1);
    bw(8'h3C, 32'h0);
    br(8'h3C, r); check("R2 zero relocks", r, 32'h1);
    bw(8'h08, 32'h0);
    br(8'h08, r); check("R2 wctl frozen when relocked", r, 32'h1);
    bw(8'h3C, 32'h1B71);
    bw(8'h3C, 32'h1B72);
    br(8'h3C, r); check("R2 wrong key relocks", r, 32'h1);
    bw(8'h3C, 32'h1B71);
  endtask

  task automatic t_wren_off;
    logic [31:0] r;
    int p0, e0;
    p0 = prog_cnt; e0 = erase_cnt;
    bw(8'h08, 32'h0);
    latch(32'h104);
    bw(8'h18, 32'h0);
    bw(8'h0C, 32'h8);
    idle(20);
    check("R3 no program with enable clear", 32'(prog_cnt), 32'(p0));
    bw(8'h0C, 32'h2);
    idle(80);
    check("R3 no erase with enable clear", 32'(erase_cnt), 32'(e0));
    br(8'h1C, r); check("R3 status idle, data pending", r, 32'h00);
    bw(8'h08, 32'h1);
  endtask

  task automatic t_program;
    logic [31:0] r;
    int n;
    bw(8'h18, 32'hA5A5_0F0F);            // ignored: earlier word still pending
    bw(8'h0C, 32'h8);
    busy_reads(n);
    check("R6 program busy length", 32'(n), 32'(PC));
    check("R5 second data write ignored", mem[32'h104 >> 2], 32'h0);
    check("R6 program address", 32'(last_paddr), 32'h104);
    br(8'h1C, r); check("R5 data-ready back after program", r, 32'h08);
    bw(8'h18, 32'hF0F0_FFFF);
    bw(8'h0C, 32'h8);
    busy_reads(n);
    check("R6 address advanced by 4", 32'(last_paddr), 32'h108);
    check("R6 AND into stored word", mem[32'h108 >> 2], INIT_W & 32'hF0F0_FFFF);
  endtask

  task automatic t_erase;
    int n, bad;
    latch(32'h208);
    bw(8'h0C, 32'hA);                    // erase and program bits: erase wins
    busy_reads(n);
    check("R7 erase busy length", 32'(n), 32'(EC));
    check("R7 erase page base", 32'(last_eaddr), 32'h200);
    bad = 0;
    for (int i = 0; i < PB / 4; i++) if (mem[(32'h200 >> 2) + i] !== 32'hFFFF_FFFF) bad++;
    check("R7 page all ones", 32'(bad), 32'd0);
    check("R7 neighbour page untouched", mem[32'h108 >> 2], INIT_W & 32'hF0F0_FFFF);
    bw(8'h18, 32'h1234_5678);
    bw(8'h0C, 32'h8);
    busy_reads(n);
    check("R6 program after erase", mem[32'h208 >> 2], 32'h1234_5678);
  endtask

  task automatic t_locked;
    logic [31:0] r;
    int p0, e0, n;
    p0 = prog_cnt; e0 = erase_cnt;
    latch(32'h300);
    br(8'h1C, r); check("R4 protected page flag", r, 32'h0A);
    bw(8'h18, 32'hDEAD_BEEF);
    bw(8'h0C, 32'h8);
    idle(20);
    check("R8 program on protected page", 32'(prog_cnt), 32'(p0));
    bw(8'h0C, 32'h2);
    idle(80);
    check("R8 erase on protected page", 32'(erase_cnt), 32'(e0));
    br(8'h1C, r); check("R8 erase-aborted flag", r, 32'h22);
    bw(8'h10, 32'h004);
    bw(8'h0C, 32'h3);                    // latch plus erase: latch only
    br(8'h1C, r); check("R4 latch clears flags, latch only", r, 32'h00);
    check("R4 combined write started no erase", 32'(erase_cnt), 32'(e0));
    bw(8'h0C, 32'h8);
    busy_reads(n);
    check("R6 pending word lands after relatch", mem[1], INIT_W & 32'hDEAD_BEEF);
  endtask

  task automatic t_invalid;
    logic [31:0] r;
    latch(32'h1000);
    br(8'h1C, r); check("R4 address at flash size invalid", r, 32'h0C);
    latch(32'h102);
    br(8'h1C, r); check("R4 misaligned invalid", r, 32'h0C);
    latch(32'hFFC);
    br(8'h1C, r); check("R4 last word valid", r, 32'h08);
  endtask

  task automatic t_timeout;
    logic [31:0] r;
    int p0;
    p0 = prog_cnt;
    bw(8'h0C, 32'h8);
    idle(20);
    br(8'h1C, r); check("R9 word timeout flag", r, 32'h18);
    check("R9 no program without data", 32'(prog_cnt), 32'(p0));
    latch(32'hFFC);
    br(8'h1C, r); check("R9 latch clears timeout", r, 32'h08);
  endtask

  task automatic t_busy;
    logic [31:0] r;
    int e0, n;
    e0 = erase_cnt;
    latch(32'h200);
    bw(8'h0C, 32'h2);
    bw(8'h10, 32'h000);
    bw(8'h0C, 32'h1);                    // ignored: busy
    bw(8'h18, 32'h0F0F_0F0F);
    bw(8'h0C, 32'h8);                    // ignored: busy
    busy_reads(n);
    check("R10 one erase only", 32'(erase_cnt), 32'(e0 + 1));
    check("R10 erase kept its address", 32'(last_eaddr), 32'h200);
    br(8'h1C, r); check("R10 program during busy dropped", r, 32'h00);
    bw(8'h0C, 32'h8);
    busy_reads(n);
    check("R10 latch during busy dropped", mem[32'h200 >> 2], 32'h0F0F_0F0F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_key();
    t_wren_off();
    t_program();
    t_erase();
    t_locked();
    t_invalid();
    t_timeout();
    t_busy();
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule